// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block folds the level-sensitive interrupt requests of up to 32 device slots onto four shared bus interrupt lines. Every slot owns four request inputs. The line that a request lands on depends on both the slot number and the pin number, so neighbouring slots spread their first pin across different lines. This keeps the load on the shared lines balanced when most devices only use their first pin.

The block does not simply OR the requests together. It keeps the last sampled level of every request and one counter per bus line. The counter holds the number of requests that are currently raised on that line, and a line is driven high while its counter is non-zero. A counter moves only when a request changes level. When several requests mapped to the same line change in one clock, they produce a single net adjustment. A synchronous reset clears every counter, every remembered request level and every output.

Top module: `irq_line_merger`

## Requirements
- R1: The request input carries 32 slots of 4 pins each; the request for slot s, pin p is bit `s*4+p` of `req_i`, and a 1 means raised.
- R2: A request for slot s, pin p is counted on bus line `(s + p) mod 4`, which is bit `(s+p)%4` of `line_o`.
- R3: When a request is sampled at a level that differs from its stored level, the stored level takes the new value. The counter of the mapped line goes up by one on a rise and down by one on a fall.
- R4: A request sampled at the same level as its stored level leaves every counter and output unchanged, however long it is held.
- R5: Each bit of `line_o` is 1 exactly when the counter of that line is non-zero. A line therefore stays high while any request mapped to it remains raised.
- R6: Rises and falls on one line in the same cycle are summed into one net change. A rise and a fall together leave the line unchanged.
- R7: Requests are sampled on the rising clock edge and `line_o` is registered. A change driven between two edges appears on `line_o` just after the next edge, and not before it.
- R8: While `rst` is high at a rising edge, all counters, stored levels and `line_o` are cleared. A request held high through reset is counted at the first edge after `rst` falls.
- R9: Each counter is wide enough to hold 128. With all 128 requests raised, every line is high, and the count per line stays exact as requests are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 128 | Level requests, bit s*4+p for slot s, pin p |
| line_o | output | 4 | Registered shared bus interrupt lines |

## Verification
Every result of this block is due at a single edge: a request level driven between two rising edges is sampled at the next edge. At that same edge the stored level, the line counter and the registered line output all update. The bench therefore drives inputs on the falling edge and checks `line_o` one time unit after the following rising edge. One directed check also samples just before that edge, to confirm that the old value still holds. A reset check follows the same rule: the outputs are read after the edge at which `rst` is high, and the first edge after release is checked for requests that were held high through reset.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Bus line that carries a given slot/pin request.
  function automatic int unsigned route_line(input int unsigned slot,
                                             input int unsigned pin,
                                             input int unsigned nlines);
    return (slot + pin) % nlines;
  endfunction

  // Bits needed to hold a count from 0 up to total inclusive.
  function automatic int unsigned count_bits(input int unsigned total);
    return $clog2(total + 1);
  endfunction

endpackage

// File: rtl/irq_req_tracker.sv
module irq_req_tracker #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned PINS      = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS*PINS-1:0] req_i,
  output logic [NUM_SLOTS*PINS-1:0] state_q,
  output logic [NUM_SLOTS*PINS-1:0] rise_o,
  output logic [NUM_SLOTS*PINS-1:0] fall_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned BASE = s * PINS;
    logic [PINS-1:0] lvl_q;
    logic [PINS-1:0] now;

    assign now = req_i[BASE +: PINS];

    always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= now;
    end

    assign state_q[BASE +: PINS] = lvl_q;
    assign rise_o[BASE +: PINS]  = now & ~lvl_q;
    assign fall_o[BASE +: PINS]  = ~now & lvl_q;
  end

endmodule

// File: rtl/irq_line_tally.sv
module irq_line_tally
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned PINS      = 4,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned CW        = 8
) (
  input  logic [NUM_SLOTS*PINS-1:0] rise_i,
  input  logic [NUM_SLOTS*PINS-1:0] fall_i,
  output logic [NUM_LINES*CW-1:0]   up_o,
  output logic [NUM_LINES*CW-1:0]   dn_o
);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CW-1:0] up;
    logic [CW-1:0] dn;

    always_comb begin
      up = '0;
      dn = '0;
      for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
        for (int unsigned p = 0; p < PINS; p++) begin
          if (route_line(s, p, NUM_LINES) == l) begin
            up = up + {{(CW-1){1'b0}}, rise_i[s*PINS+p]};
            dn = dn + {{(CW-1){1'b0}}, fall_i[s*PINS+p]};
          end
        end
      end
    end

    assign up_o[l*CW +: CW] = up;
    assign dn_o[l*CW +: CW] = dn;
  end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] up_i,
  input  logic [CW-1:0] dn_i,
  output logic [CW-1:0] cnt_q,
  output logic          line_q
);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] up,
                                               input logic [CW-1:0] dn);
    return cur + up - dn;
  endfunction

  logic [CW-1:0] cnt_next;
  assign cnt_next = next_count(cnt_q, up_i, dn_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      line_q <= (cnt_next != '0);
    end
  end

endmodule

// File: rtl/irq_line_merger.sv
module irq_line_merger
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned PINS      = 4,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS*PINS-1:0] req_i,
  output logic [NUM_LINES-1:0]      line_o
);

  localparam int unsigned TOTAL = NUM_SLOTS * PINS;
  localparam int unsigned CW    = count_bits(TOTAL);

  // Named internal events, visible to the bound checker.
  logic [TOTAL-1:0]        req_state;
  logic [TOTAL-1:0]        req_rise;
  logic [TOTAL-1:0]        req_fall;
  logic [NUM_LINES*CW-1:0] line_up;
  logic [NUM_LINES*CW-1:0] line_dn;
  logic [NUM_LINES*CW-1:0] cnt_flat;

  irq_req_tracker #(.NUM_SLOTS(NUM_SLOTS), .PINS(PINS)) u_track (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .state_q (req_state),
    .rise_o  (req_rise),
    .fall_o  (req_fall)
  );

  irq_line_tally #(.NUM_SLOTS(NUM_SLOTS), .PINS(PINS),
                   .NUM_LINES(NUM_LINES), .CW(CW)) u_tally (
    .rise_i (req_rise),
    .fall_i (req_fall),
    .up_o   (line_up),
    .dn_o   (line_dn)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
    irq_line_counter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .up_i   (line_up[l*CW +: CW]),
      .dn_i   (line_dn[l*CW +: CW]),
      .cnt_q  (cnt_flat[l*CW +: CW]),
      .line_q (line_o[l])
    );
  end

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int unsigned TOTAL     = 128,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned CW        = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [TOTAL-1:0]          req_i,
  input logic [TOTAL-1:0]          req_state,
  input logic [NUM_LINES*CW-1:0]   cnt_flat,
  input logic [NUM_LINES-1:0]      line_o
);

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  int unsigned cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int unsigned l = 0; l < NUM_LINES; l++)
      cnt_sum = cnt_sum + int'(cnt_flat[l*CW +: CW]);
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    past_valid && $past(rst) |-> (cnt_flat == '0) && (req_state == '0) && (line_o == '0));

  // R3
  state_track_chk: assert property (@(posedge clk) disable iff (rst)
    past_valid && !$past(rst) |-> req_state == $past(req_i));

  // R4
  no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i == req_state) |=> $stable(cnt_flat) && $stable(line_o));

  // R6
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_sum == $countones(req_state));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_lchk
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      int'(cnt_flat[l*CW +: CW]) <= TOTAL);
  end

endmodule

bind irq_line_merger irq_merge_chk #(
  .TOTAL(TOTAL), .NUM_LINES(NUM_LINES), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .req_state (req_state),
  .cnt_flat  (cnt_flat),
  .line_o    (line_o)
);

// File: tb/irq_line_merger_tb.sv
`timescale 1ns/1ps
module irq_line_merger_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] req = '0;
  logic [3:0]   line_o;
  logic [127:0] model = '0;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  irq_line_merger u_dut (.clk(clk), .rst(rst), .req_i(req), .line_o(line_o));

  // Line l collects slot s on pin (l - s) mod 4.
  function automatic logic [3:0] exp_lines(input logic [127:0] st);
    logic [3:0] e;
    for (int l = 0; l < 4; l++) begin
      int hits;
      hits = 0;
      for (int s = 0; s < 32; s++) begin
        int pin;
        pin = (l + 4 - (s % 4)) % 4;
        if (st[s*4 + pin]) hits++;
      end
      e[l] = (hits > 0);
    end
    return e;
  endfunction

  function automatic logic [127:0] bit_at(input int slot, input int pin);
    logic [127:0] v;
    v = '0;
    v[slot*4 + pin] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (line_o !== exp) begin
      errors++;
      $display("FAIL %s line_o=%b expected=%b", tag, line_o, exp);
    end
  endtask

  task automatic apply(input logic [127:0] v, input string tag);
    @(negedge clk);
    req = v;
    @(posedge clk);
    #1;
    model = v;
    check(tag, exp_lines(model));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset state", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R8 idle after reset", 4'b0000);

    // R1 R2 R3: single requests land on (s+p)%4
    apply(bit_at(0, 0), "R2 slot0 pin0 -> line0");
    check("R2 line0 only", 4'b0001);
    apply(bit_at(0, 0) | bit_at(1, 3), "R1 slot1 pin3 also line0");
    apply(bit_at(1, 3), "R3 drop one of two keeps line0");
    check("R5 line0 held by remaining request", 4'b0001);
    apply(bit_at(2, 3), "R2 slot2 pin3 -> line1 and fall on line0");
    check("R3 exact lines", 4'b0010);
    apply(bit_at(2, 3) | bit_at(31, 3), "R2 slot31 pin3 -> line2");
    check("R2 line2", 4'b0110);

    // R4: hold same level
    for (int i = 0; i < 6; i++) apply(bit_at(2, 3) | bit_at(31, 3), "R4 held level");
    check("R4 unchanged after hold", 4'b0110);

    // R6: rise and fall on line 1 in one cycle -> net zero
    apply(bit_at(3, 2) | bit_at(31, 3), "R6 swap on line1");
    check("R6 line1 stays high", 4'b0110);
    apply(bit_at(5, 0) | bit_at(6, 3) | bit_at(7, 2), "R6 three rises line1 + falls");
    check("R6 multi rise", 4'b0010);
    apply(bit_at(6, 3), "R6 two falls one cycle");
    check("R6 line1 still counted", 4'b0010);
    apply('0, "R3 all low");
    check("R3 all lines low", 4'b0000);

    // R7: output waits for the edge
    @(negedge clk);
    req = bit_at(0, 1);
    #2;
    check("R7 before edge old value", 4'b0000);
    @(posedge clk);
    #1;
    model = req;
    check("R7 after edge", 4'b0010);

    // R9: all requests raised, then released in stages
    apply({128{1'b1}}, "R9 all raised");
    check("R9 all lines high", 4'b1111);
    v = {128{1'b1}};
    for (int s = 0; s < 32; s++) v[s*4 + ((4 - (s % 4)) % 4)] = 1'b0;
    apply(v, "R9 line0 fully released");
    check("R9 line0 low others high", 4'b1110);
    apply(bit_at(9, 0), "R9 only slot9 pin0");
    check("R9 line1 exact", 4'b0010);

    // R8: request held through reset
    @(negedge clk);
    req = bit_at(4, 3) | bit_at(0, 2);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R8 reset clears outputs", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    @(posedge clk);
    #1;
    model = req;
    check("R8 held request counted after reset", 4'b1100);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      v = model;
      if ($urandom % 8 == 0) v = {$urandom, $urandom, $urandom, $urandom};
      else begin
        int nflip;
        nflip = int'($urandom % 4);
        for (int k = 0; k < nflip; k++) v[$urandom % 128] = ~v[$urandom % 128];
      end
      apply(v, "R3 random traffic");
    end

    apply('0, "R5 final release");
    check("R5 all low at end", 4'b0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule